// File: doc/BRIEF.md
# Pipelined Full-Adder Population Counter

This block counts how many bits of a wide input vector are set and returns the count in binary. It is built only from registered one-bit full adders. The adders are arranged as a set of overlapping reduction trees, one tree for each result bit. The first tree takes the raw input bits, and its root sum gives the least significant bit of the count. The carries of each tree feed the next, smaller tree, whose root sum gives the next more significant bit.

Every adder output is registered. A later tree starts work on carries in the cycle after they are produced, so the trees run at the same time. Single leftover bits pass through delay registers, which keeps every result bit for one vector in the same output cycle. The block takes a new vector on every clock. A valid flag follows each vector through the pipeline and marks the cycle in which its count is presented.

Input widths of any size are accepted. A width that is not one less than a power of two is treated as if the missing inputs were zero. The block is used wherever a fast popcount is needed at full clock rate, for example in Hamming-distance units and in bit-density monitors.

Top module: `fa_popcount_pipe`

## Requirements
- R1: When `out_valid` is 1, `out_count` equals the number of 1 bits in the `in_bits` vector that was accepted with `in_valid` = 1 exactly the pipeline latency earlier.
- R2: `out_count` is floor(log2(IN_W))+1 bits wide. An all-ones input gives exactly IN_W, with no wrap (for IN_W = 15 that is 15 on a 4-bit output).
- R3: The latency is fixed. `out_valid` rises exactly the latency number of clock edges after the edge that accepts a vector. The latency is 6 cycles for IN_W = 15 and also 6 cycles for IN_W = 10.
- R4: The block accepts a vector on every clock. Back-to-back vectors give back-to-back results, and each result belongs to its own vector.
- R5: A cycle with `in_valid` = 0 produces a cycle with `out_valid` = 0 at the output, one latency later.
- R6: A synchronous active-high `rst` clears `out_valid` and `out_count` to 0 at the next edge and discards every vector in flight. While `rst` is 1, `in_valid` is ignored.
- R7: The count is exact for input widths that are not one less than a power of two (checked with IN_W = 10).
- R8: An all-zero input vector gives a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `in_bits` as a vector to count in this cycle |
| in_bits | input | IN_W | Bits to be counted |
| out_valid | output | 1 | Marks `out_count` as the count of an accepted vector |
| out_count | output | floor(log2(IN_W))+1 | Binary count of ones, registered |

## Verification
The bench builds two copies of the block side by side. One has IN_W = 15, which fills every tree completely. The other has IN_W = 10, where trees have leftover single bits and two-bit groups, so the delay registers and the zero-padded adders are exercised. Both copies get the same stimulus, and both are expected to show a latency of 6. This lets the bench check alignment with one fixed offset, and it shows that the carry trees settle at the same depth even when the first tree is only partly filled.

// File: rtl/popc_pkg.sv
package popc_pkg;

  localparam int MAX_COLS = 32;

  // Result width: floor(log2(b)) + 1.
  function automatic int out_width(input int b);
    int w;
    w = 1;
    while ((1 << w) <= b) w++;
    return w;
  endfunction

  // Adder groups that a column of n bits is split into (triples, then a remainder).
  function automatic int n_groups(input int n);
    return (n + 2) / 3;
  endfunction

  // Groups that produce a carry: full triples, and a remainder of two bits.
  function automatic int n_carries(input int n);
    return (n / 3) + (((n % 3) == 2) ? 1 : 0);
  endfunction

  // Bits held in column c after s register levels.
  function automatic int col_count(input int b, input int ow, input int s, input int c);
    int n  [MAX_COLS];
    int nx [MAX_COLS];
    for (int k = 0; k < MAX_COLS; k++) begin
      n[k]  = 0;
      nx[k] = 0;
    end
    n[0] = b;
    for (int t = 0; t < s; t++) begin
      for (int k = 0; k < ow; k++) begin
        nx[k] = n_groups(n[k]);
        if (k > 0) nx[k] = nx[k] + n_carries(n[k-1]);
      end
      for (int k = 0; k < ow; k++) n[k] = nx[k];
    end
    return n[c];
  endfunction

  // Position of column c inside the flat vector of level s.
  function automatic int col_offset(input int b, input int ow, input int s, input int c);
    int acc;
    acc = 0;
    for (int k = 0; k < c; k++) acc = acc + col_count(b, ow, s, k);
    return acc;
  endfunction

  function automatic int level_width(input int b, input int ow, input int s);
    return col_offset(b, ow, s, ow);
  endfunction

  // Number of register levels until every column holds at most one bit.
  function automatic int level_count(input int b, input int ow);
    int worst;
    for (int s = 0; s < 4 * ow + 8; s++) begin
      worst = 0;
      for (int c = 0; c < ow; c++)
        if (col_count(b, ow, s, c) > worst) worst = col_count(b, ow, s, c);
      if (worst <= 1) return s;
    end
    return 4 * ow + 8;
  endfunction

endpackage

// File: rtl/popc_fa_cell.sv
module popc_fa_cell (
  input  logic clk,
  input  logic rst,
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic sum_q,
  output logic carry_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q   <= 1'b0;
      carry_q <= 1'b0;
    end else begin
      sum_q   <= a ^ b ^ ci;
      carry_q <= (a & b) | (a & ci) | (b & ci);
    end
  end

endmodule

// File: rtl/popc_level.sv
// One register level of all trees: every column is cut into groups of up to
// three bits. Each group yields a sum in its own column and, when it has two
// or more bits, a carry into the next column. The top column keeps sums only.
module popc_level
  import popc_pkg::*;
#(
  parameter int B  = 15,
  parameter int OW = 4,
  parameter int S  = 0,
  localparam int TIN  = level_width(B, OW, S),
  localparam int TOUT = level_width(B, OW, S + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TIN-1:0]  din,
  output logic [TOUT-1:0] dout
);

  for (genvar c = 0; c < OW; c++) begin : g_col
    localparam int N   = col_count(B, OW, S, c);
    localparam int G   = n_groups(N);
    localparam int OFI = col_offset(B, OW, S, c);
    localparam int OFO = col_offset(B, OW, S + 1, c);
    // carries from this column land after the sums of the next column
    localparam int OFN = (c < OW - 1) ?
                         col_offset(B, OW, S + 1, c + 1) + n_groups(col_count(B, OW, S, c + 1)) : 0;

    for (genvar g = 0; g < G; g++) begin : g_grp
      localparam int SZ = ((N - 3 * g) >= 3) ? 3 : (N - 3 * g);

      if (c == OW - 1) begin : g_top
        logic sq;
        always_ff @(posedge clk) begin
          if (rst) sq <= 1'b0;
          else     sq <= ^din[OFI + 3 * g +: SZ];
        end
        assign dout[OFO + g] = sq;
      end else if (SZ == 1) begin : g_dly
        logic dq;
        always_ff @(posedge clk) begin
          if (rst) dq <= 1'b0;
          else     dq <= din[OFI + 3 * g];
        end
        assign dout[OFO + g] = dq;
      end else begin : g_fa
        logic ci_w, s_w, c_w;
        if (SZ == 3) begin : g_three
          assign ci_w = din[OFI + 3 * g + 2];
        end else begin : g_two
          assign ci_w = 1'b0;
        end
        popc_fa_cell u_fa (
          .clk     (clk),
          .rst     (rst),
          .a       (din[OFI + 3 * g]),
          .b       (din[OFI + 3 * g + 1]),
          .ci      (ci_w),
          .sum_q   (s_w),
          .carry_q (c_w)
        );
        assign dout[OFO + g] = s_w;
        assign dout[OFN + g] = c_w;
      end
    end
  end

endmodule

// File: rtl/popc_valid_line.sv
module popc_valid_line #(
  parameter int DEPTH = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic vin,
  output logic vout
);

  if (DEPTH == 0) begin : g_none
    assign vout = vin;
  end else begin : g_shift
    logic [DEPTH-1:0] sr;
    always_ff @(posedge clk) begin
      if (rst) begin
        sr <= '0;
      end else begin
        sr[0] <= vin;
        for (int k = 1; k < DEPTH; k++) sr[k] <= sr[k-1];
      end
    end
    assign vout = sr[DEPTH-1];
  end

endmodule

// File: rtl/fa_popcount_pipe.sv
module fa_popcount_pipe
  import popc_pkg::*;
#(
  parameter int IN_W = 15,
  localparam int CNT_W = out_width(IN_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_bits,
  output logic             out_valid,
  output logic [CNT_W-1:0] out_count
);

  localparam int LAT = level_count(IN_W, CNT_W);

  for (genvar s = 0; s < LAT; s++) begin : g_lvl
    logic [level_width(IN_W, CNT_W, s + 1)-1:0] q;
    if (s == 0) begin : g_first
      popc_level #(.B(IN_W), .OW(CNT_W), .S(s)) u_level (
        .clk  (clk),
        .rst  (rst),
        .din  (in_bits),
        .dout (q)
      );
    end else begin : g_next
      popc_level #(.B(IN_W), .OW(CNT_W), .S(s)) u_level (
        .clk  (clk),
        .rst  (rst),
        .din  (g_lvl[s-1].q),
        .dout (q)
      );
    end
  end

  if (LAT == 0) begin : g_wire
    assign out_count = CNT_W'(in_bits);
  end else begin : g_reg
    assign out_count = g_lvl[LAT-1].q;
  end

  popc_valid_line #(.DEPTH(LAT)) u_vline (
    .clk  (clk),
    .rst  (rst),
    .vin  (in_valid & ~rst),
    .vout (out_valid)
  );

endmodule

// File: rtl/popc_pipe_checker.sv
module popc_pipe_checker #(
  parameter int IN_W  = 15,
  parameter int CNT_W = 4,
  parameter int LAT   = 6,
  localparam int D = (LAT < 1) ? 1 : LAT
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [IN_W-1:0]  in_bits,
  input logic             out_valid,
  input logic [CNT_W-1:0] out_count
);

  logic [D-1:0]     mv;
  logic [CNT_W-1:0] mc [D];

  always_ff @(posedge clk) begin
    if (rst) begin
      mv <= '0;
      for (int k = 0; k < D; k++) mc[k] <= '0;
    end else begin
      mv[0] <= in_valid;
      mc[0] <= CNT_W'($countones(in_bits));
      for (int k = 1; k < D; k++) begin
        mv[k] <= mv[k-1];
        mc[k] <= mc[k-1];
      end
    end
  end

  assert_reset_clear_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && out_count == '0));

  assert_valid_align_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid == mv[D-1]);

  assert_count_match_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_count == mc[D-1]);

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> 32'(out_count) <= IN_W);

endmodule

bind fa_popcount_pipe popc_pipe_checker #(
  .IN_W  (IN_W),
  .CNT_W (CNT_W),
  .LAT   (LAT)
) u_popc_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_bits   (in_bits),
  .out_valid (out_valid),
  .out_count (out_count)
);

// File: tb/fa_popcount_pipe_bench.sv
module fa_popcount_pipe_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W_A     = 15;
  localparam int W_B     = 10;
  localparam int CW      = 4;
  localparam int EXP_LAT = 6;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic [W_A-1:0] in_bits = '0;
  logic           ov_a, ov_b;
  logic [CW-1:0]  oc_a, oc_b;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  logic           hv [16];
  logic [W_A-1:0] hb [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  fa_popcount_pipe #(.IN_W(W_A)) u_fa_popcount_pipe (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_bits (in_bits),
    .out_valid (ov_a), .out_count (oc_a)
  );

  fa_popcount_pipe #(.IN_W(W_B)) u_fa_popcount_pipe_w10 (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_bits (in_bits[W_B-1:0]),
    .out_valid (ov_b), .out_count (oc_b)
  );

  function automatic int ones(input logic [W_A-1:0] v, input int w);
    int n;
    n = 0;
    for (int i = 0; i < w; i++) if (v[i]) n++;
    return n;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic check_outputs();
    int  idx, pidx, ea, eb;
    bit  ev, pv;
    string ta, tb;
    if (rst) begin
      chk(ov_a == 1'b0, "R6", "out_valid in reset", int'(ov_a), 0);
      chk(oc_a == '0,   "R6", "count in reset",     int'(oc_a), 0);
      chk(ov_b == 1'b0, "R6", "w10 out_valid in reset", int'(ov_b), 0);
      return;
    end
    ev = 1'b0;
    pv = 1'b0;
    idx = 0;
    if (cyc >= EXP_LAT) begin
      idx = (cyc - EXP_LAT) % 16;
      ev  = hv[idx];
      if (cyc > EXP_LAT) begin
        pidx = (cyc - EXP_LAT - 1) % 16;
        pv   = hv[pidx];
      end
    end
    chk(ov_a == ev, ev ? "R3" : "R5", "out_valid", int'(ov_a), int'(ev));
    chk(ov_b == ev, ev ? "R3" : "R5", "w10 out_valid", int'(ov_b), int'(ev));
    if (ev) begin
      ea = ones(hb[idx], W_A);
      eb = ones(hb[idx], W_B);
      if (ea == W_A)    ta = "R2";
      else if (ea == 0) ta = "R8";
      else if (pv)      ta = "R4";
      else              ta = "R1";
      chk(int'(oc_a) == ea, ta, "count", int'(oc_a), ea);
      tb = (eb == 0) ? "R8" : "R7";
      chk(int'(oc_b) == eb, tb, "w10 count", int'(oc_b), eb);
    end
  endtask

  task automatic step(input bit v, input logic [W_A-1:0] bits, input bit r);
    @(negedge clk);
    check_outputs();
    rst      = r;
    in_valid = v;
    in_bits  = bits;
    if (r) for (int k = 0; k < 16; k++) hv[k] = 1'b0;
    hv[cyc % 16] = v && !r;
    hb[cyc % 16] = bits;
    cyc++;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    for (int k = 0; k < 16; k++) begin
      hv[k] = 1'b0;
      hb[k] = '0;
    end
    void'($urandom(32'd90210));

    for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1);

    // directed corner cases
    step(1'b1, 15'h7FFF, 1'b0);
    step(1'b1, 15'h0000, 1'b0);
    step(1'b1, 15'h7FFF, 1'b0);
    step(1'b1, 15'h5555, 1'b0);
    step(1'b1, 15'h2AAA, 1'b0);
    for (int i = 0; i < W_A; i++) step(1'b1, 15'(1 << i), 1'b0);
    for (int i = 0; i < 4; i++) step(1'b1, 15'h7FFF, 1'b0);
    step(1'b1, 15'h03FF, 1'b0);
    step(1'b1, 15'h7C00, 1'b0);
    // bubbles with busy data on the bus
    for (int i = 0; i < 3; i++) step(1'b0, 15'h7FFF, 1'b0);
    step(1'b1, 15'h0000, 1'b0);
    step(1'b0, 15'h1234, 1'b0);
    step(1'b1, 15'h7FFF, 1'b0);

    // random stream
    for (int i = 0; i < 2000; i++) begin
      logic [W_A-1:0] r;
      r = W_A'($urandom);
      if ((i % 97) == 0) r = '1;
      if ((i % 89) == 0) r = '0;
      step(($urandom % 4) != 0, r, 1'b0);
    end

    // reset in the middle of a stream, with in_valid held high during reset
    for (int i = 0; i < 5; i++) step(1'b1, W_A'($urandom), 1'b0);
    step(1'b1, 15'h7FFF, 1'b1);
    step(1'b1, 15'h7FFF, 1'b1);
    for (int i = 0; i < 20; i++) step(1'b1, W_A'($urandom), 1'b0);

    for (int i = 0; i < 10; i++) step(1'b0, '0, 1'b0);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    finish_run();
  end

endmodule